// File: doc/BRIEF.md
# Receive Byte FIFO with Word Readout and Fill Thresholds

This block sits between a serial receive shifter and a host register port. The shifter hands over one received byte at a time with a single-cycle strobe. The host takes the data out as 32-bit words. Each host read removes up to four bytes, with the oldest byte in the lowest lane. When fewer than four bytes remain, the word that is read holds only those bytes, packed at the bottom.

The host sees a status word and a small response-interrupt vector:

- **Status word:** an empty flag, the count of bytes held, a data-ready bit, and three fill-level bits at 16, 32 and 64 bytes.
- **Interrupt vector:** a sticky underrun bit that is set when the host reads while nothing is held, a not-empty level and a ready level.
- **Clear strobe:** a separate input empties the store in one cycle.

A three-state fill machine tracks whether the store is empty, partly filled or full. Its state register is written by one process, and a second process decodes the empty and full outputs from it. The states are:

- **FS_EMPTY:** nothing is held.
- **FS_PART:** between 1 and DEPTH-1 bytes are held.
- **FS_FULL:** DEPTH bytes are held.

The transitions are named as follows. In every case the target state is chosen from the count of the next cycle.

- **T_FILL:** from FS_EMPTY to FS_PART.
- **T_TOP:** from FS_PART to FS_FULL.
- **T_DRAIN:** from FS_FULL to FS_PART.
- **T_DRY:** from FS_PART to FS_EMPTY.
- **T_FLUSH:** from any state to FS_EMPTY when the clear strobe is applied.

Top module: `rxf_fifo`

## Requirements
- R1: After reset, fifo_status reads 0x800 (empty set, count 0, all ready bits 0) and resp_irq reads 3'b000.
- R2: fifo_status[10:4] holds the number of bytes written and not yet read. It changes on the clock edge at which the strobe is sampled, so the new value is visible in the next cycle.
- R3: fifo_status[11] is 1 exactly when the count is 0.
- R4: fifo_status[0] is 1 when the count is at least 4. Bits 1, 2 and 3 are 1 when the count is at least 16, 32 and 64 respectively.
- R5: word_data presents the oldest held byte in bits 7:0, the next in 15:8, the next in 23:16 and the fourth in 31:24. The value is valid combinationally in any cycle, and a read strobe consumes it.
- R6: When 1 to 3 bytes are held, word_data carries them in the lowest byte lanes with the unused upper lanes zero. Each read strobe removes min(4, count) bytes.
- R7: A read strobe while the count is 0 removes nothing and sets resp_irq[0] in the next cycle. The bit stays set until uflow_ack is pulsed. A set and an ack in the same cycle leave it set. word_data reads 0 while the count is 0.
- R8: resp_irq[1] equals (count != 0) and resp_irq[2] equals (count >= 4).
- R9: fifo_clear empties the store and clears resp_irq[0] in the next cycle, and it takes priority over a byte strobe or read strobe in the same cycle.
- R10: The store holds DEPTH bytes (64 by default). A byte strobed while the count equals DEPTH is dropped, even when a read occurs in the same cycle.
- R11: A byte strobe and a read strobe in the same cycle give a count of old - min(4, old) + 1, and the new byte is queued behind the remaining bytes.
- R12: The fill machine moves among FS_EMPTY, FS_PART and FS_FULL according to the next count. A store in FS_FULL rejects new bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Byte strobe from the receive shifter |
| byte_data | input | 8 | Received byte |
| word_rd | input | 1 | Host word read strobe |
| word_data | output | 32 | Word presented to the host, oldest byte lowest |
| fifo_clear | input | 1 | Empty the store |
| uflow_ack | input | 1 | Clear the sticky underrun bit |
| fifo_status | output | 12 | {empty, count[6:0], ge64, ge32, ge16, ready} |
| resp_irq | output | 3 | {ready, not-empty, underrun} |

## Verification
The hardest situation to reach is a read strobe that coincides with a byte strobe while the store is full. In that case the byte must be dropped, even though a pop in the same cycle leaves room. Hitting it needs 64 back-to-back bytes and then a combined strobe at exactly that count. The stimulus fills the store with a counted loop, checks the 64-byte threshold, and then drives both strobes together. A randomized phase afterwards mixes all strobes, including partial-word reads, reads on an empty store, and ack pulses that coincide with underruns, and compares against a byte-queue model every cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2
    } fill_state_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_valid,
    input  logic          word_rd,
    input  logic          fifo_clear,
    input  logic          uflow_ack,
    output logic [CW-1:0] count,
    output logic [2:0]    avail,
    output logic [2:0]    pop_n,
    output logic          push,
    output logic          is_empty,
    output logic          uflow
);
    import rxf_pkg::*;

    fill_state_t   state, state_nxt;
    logic [CW-1:0] count_nxt;
    logic          is_full;

    // Bytes one host read would remove.
    always_comb begin
        if (count >= CW'(WORD_BYTES)) avail = 3'(WORD_BYTES);
        else                          avail = count[2:0];
    end

    assign pop_n = (word_rd && !fifo_clear) ? avail : 3'd0;
    assign push  = byte_valid && !fifo_clear && !is_full;

    always_comb begin
        if (fifo_clear) count_nxt = '0;
        else            count_nxt = count - CW'(pop_n) + CW'(push);
    end

    // Next-state logic: T_FLUSH, T_FILL, T_TOP, T_DRAIN, T_DRY.
    always_comb begin
        state_nxt = state;
        unique case (state)
            FS_EMPTY: if (count_nxt != '0) state_nxt = (count_nxt == CW'(DEPTH)) ? FS_FULL : FS_PART;
            FS_PART:  if (count_nxt == '0) state_nxt = FS_EMPTY;
                      else if (count_nxt == CW'(DEPTH)) state_nxt = FS_FULL;
            FS_FULL:  if (count_nxt == '0) state_nxt = FS_EMPTY;
                      else if (count_nxt != CW'(DEPTH)) state_nxt = FS_PART;
            default:  state_nxt = FS_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_EMPTY;
        else        state <= state_nxt;
    end

    // Output decode.
    always_comb begin
        is_empty = 1'b0;
        is_full  = 1'b0;
        unique case (state)
            FS_EMPTY: is_empty = 1'b1;
            FS_PART:  ;
            FS_FULL:  is_full  = 1'b1;
            default:  is_empty = 1'b1;
        endcase
    end

    // Count and sticky underrun.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            uflow <= 1'b0;
        end else begin
            count <= count_nxt;
            if (fifo_clear)                  uflow <= 1'b0;
            else if (word_rd && count == '0) uflow <= 1'b1;
            else if (uflow_ack)              uflow <= 1'b0;
        end
    end
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_clear,
    input  logic        push,
    input  logic [7:0]  byte_in,
    input  logic [2:0]  pop_n,
    input  logic [2:0]  avail,
    output logic [31:0] word_out
);
    import rxf_pkg::*;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= byte_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else if (fifo_clear) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + AW'(1);
            rptr <= rptr + AW'(pop_n);
        end
    end

    // One lane per byte of the host word; lanes past the held count read zero.
    for (genvar ln = 0; ln < WORD_BYTES; ln++) begin : g_lane
        logic [AW-1:0] idx;
        assign idx = rptr + AW'(ln);
        assign word_out[8*ln +: 8] = (3'(ln) < avail) ? mem[idx] : 8'h00;
    end
endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_valid,
    input  logic [7:0]    byte_data,
    input  logic          word_rd,
    output logic [31:0]   word_data,
    input  logic          fifo_clear,
    input  logic          uflow_ack,
    output logic [CW+4:0] fifo_status,
    output logic [2:0]    resp_irq
);
    logic [CW-1:0] count;
    logic [2:0]    avail, pop_n;
    logic          push, is_empty, uflow, ready;

    rxf_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .word_rd(word_rd),
        .fifo_clear(fifo_clear), .uflow_ack(uflow_ack), .count(count),
        .avail(avail), .pop_n(pop_n), .push(push), .is_empty(is_empty), .uflow(uflow)
    );

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .fifo_clear(fifo_clear), .push(push),
        .byte_in(byte_data), .pop_n(pop_n), .avail(avail), .word_out(word_data)
    );

    assign ready       = count >= CW'(4);
    assign fifo_status = {is_empty, count, count >= CW'(64), count >= CW'(32),
                          count >= CW'(16), ready};
    assign resp_irq    = {ready, !is_empty, uflow};
endmodule

// File: rtl/rxf_fifo_chk.sv
module rxf_fifo_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        byte_valid,
    input logic        word_rd,
    input logic        fifo_clear,
    input logic        uflow_ack,
    input logic [31:0] word_data,
    input logic [11:0] fifo_status,
    input logic [2:0]  resp_irq
);
    logic [6:0] cnt;
    assign cnt = fifo_status[10:4];

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_clear |=> cnt <= $past(cnt) + 7'd1); // R2
    AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_status[11] == (cnt == 7'd0)); // R3
    AST_THRESH_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_status[3] |-> (fifo_status[2] && fifo_status[1] && fifo_status[0])); // R4
    AST_PART_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 7'd1) |-> (word_data[31:8] == 24'h0)); // R6
    AST_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (word_rd && cnt == 7'd0 && !fifo_clear) |=> resp_irq[0]); // R7
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear |=> (cnt == 7'd0 && !resp_irq[0])); // R9
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 7'd64 && byte_valid && !word_rd && !fifo_clear) |=> cnt == 7'd64); // R10
endmodule

bind rxf_fifo rxf_fifo_chk u_chk (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .word_rd(word_rd),
    .fifo_clear(fifo_clear), .uflow_ack(uflow_ack), .word_data(word_data),
    .fifo_status(fifo_status), .resp_irq(resp_irq)
);

// File: tb/rxf_fifo_bench.sv
module rxf_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        word_rd = 1'b0;
    logic        fifo_clear = 1'b0;
    logic        uflow_ack = 1'b0;
    logic [31:0] word_data;
    logic [11:0] fifo_status;
    logic [2:0]  resp_irq;

    int vectors = 0;
    int errors  = 0;
    logic [7:0] q[$];
    bit m_uf = 1'b0;
    logic [7:0] seq = 8'h10;

    always #4 clk = ~clk;

    rxf_fifo u_rxf_fifo (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .word_rd(word_rd), .word_data(word_data), .fifo_clear(fifo_clear),
        .uflow_ack(uflow_ack), .fifo_status(fifo_status), .resp_irq(resp_irq)
    );

    task automatic compare(input string tag);
        int n;
        logic [31:0] ew;
        logic [11:0] es;
        logic [2:0]  ei;
        n  = q.size();
        ew = 32'h0;
        for (int i = 0; i < 4 && i < n; i++) ew[8*i +: 8] = q[i];
        es = {n == 0, 7'(n), n >= 64, n >= 32, n >= 16, n >= 4};
        ei = {n >= 4, n != 0, m_uf};
        vectors++;
        if (fifo_status[10:4] !== es[10:4]) begin errors++;
            $display("FAIL %s R2 count act=%0d exp=%0d", tag, fifo_status[10:4], es[10:4]); end
        if (fifo_status[11] !== es[11]) begin errors++;
            $display("FAIL %s R3 empty act=%b exp=%b", tag, fifo_status[11], es[11]); end
        if (fifo_status[3:0] !== es[3:0]) begin errors++;
            $display("FAIL %s R4 thresholds act=%b exp=%b", tag, fifo_status[3:0], es[3:0]); end
        if (word_data !== ew) begin errors++;
            $display("FAIL %s R5/R6 word act=%h exp=%h", tag, word_data, ew); end
        if (resp_irq[0] !== ei[0]) begin errors++;
            $display("FAIL %s R7 underrun act=%b exp=%b", tag, resp_irq[0], ei[0]); end
        if (resp_irq[2:1] !== ei[2:1]) begin errors++;
            $display("FAIL %s R8 irq levels act=%b exp=%b", tag, resp_irq[2:1], ei[2:1]); end
    endtask

    // Drive at negedge, compare model, apply edge to model.
    task automatic cyc(input bit wr, input bit rd, input bit clr, input bit ack, input string tag);
        int n;
        logic [7:0] b;
        @(negedge clk);
        b = seq;
        byte_valid = wr; byte_data = b; word_rd = rd; fifo_clear = clr; uflow_ack = ack;
        #1 compare(tag);
        @(posedge clk);
        n = q.size();
        if (clr) begin
            q.delete(); m_uf = 1'b0;                 // R9
        end else begin
            if (rd && n == 0) m_uf = 1'b1;           // R7
            else if (ack) m_uf = 1'b0;
            if (rd) for (int i = 0; i < 4 && i < n; i++) void'(q.pop_front()); // R6
            if (wr && n < 64) q.push_back(b);        // R10, R11
        end
        if (wr) seq = seq + 8'd7;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 compare("reset R1");
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, "load6 R2");
        cyc(0, 1, 0, 0, "word R5");
        cyc(0, 1, 0, 0, "partial R6");
        cyc(0, 0, 0, 0, "drained R3");
        cyc(0, 1, 0, 0, "empty read R7");
        cyc(0, 0, 0, 0, "sticky R7");
        cyc(0, 1, 0, 1, "set beats ack R7");
        cyc(0, 0, 0, 1, "ack R7");
        cyc(0, 0, 0, 0, "acked R7");

        for (int i = 0; i < 70; i++) cyc(1, 0, 0, 0, "fill R4 R10 R12");
        cyc(1, 1, 0, 0, "full rd+wr drop R10");
        cyc(1, 1, 0, 0, "rd+wr R11");
        for (int i = 0; i < 17; i++) cyc(0, 1, 0, 0, "drain R12");
        cyc(1, 0, 0, 0, "one R6");
        cyc(1, 1, 0, 0, "rd+wr single R11");
        cyc(0, 0, 0, 0, "after R11");
        for (int i = 0; i < 9; i++) cyc(1, 0, 0, 0, "refill R2");
        cyc(0, 1, 0, 0, "pre-uf");
        cyc(1, 1, 1, 0, "clear prio R9");
        cyc(0, 0, 0, 0, "cleared R9");
        cyc(0, 1, 0, 0, "uf again R7");
        cyc(0, 0, 1, 0, "clear uf R9");

        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            cyc(r < 55, (r % 3) == 0, r == 97, (r % 11) == 0, "random R12");
        end
        cyc(0, 0, 0, 0, "final");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule